// File: doc/BRIEF.md
# Virtual Address Region Classifier

This block sits in front of an address-translation lookup and decides what kind of access a virtual address is. It looks at the upper address bits, the current privilege level, a translation-enable control and a control that locks user code out of the store-queue window. Each request is given one of four class codes: pass through untranslated, send to the translation lookup, store-queue access, or address error.

For requests that need translation, the block also delivers the lookup key: the page number (the address with its low ten offset bits dropped) and the address-space identifier that was current when the request was accepted. The decision logic is combinational. The result is held in one output register, with a valid/ready handshake on both sides, so one request per cycle can flow while the consumer keeps accepting.

Top module: `vaddr_region_sort`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `req_ready` is 1.
- R2: In privileged mode (`req_priv`=1), an address whose bits [31:29] are 100 or 101 gets class 0 (pass), whatever `xlat_on` is.
- R3: In privileged mode, an address whose bits [31:29] are 111 gets class 0 (pass), whatever `xlat_on` is.
- R4: In privileged mode, an address whose bits [31:29] are 000, 001, 010, 011 or 110 gets class 1 (translate) when `xlat_on`=1 and class 0 when `xlat_on`=0.
- R5: In user mode (`req_priv`=0), an address with bit 31 set gets class 3 (address error). The only exception is an address whose bits [31:26] are 111000 (0xE0000000 to 0xE3FFFFFF) while `sq_lock`=0, which gets class 2 (store queue).
- R6: In user mode, an address with bit 31 clear gets class 1 when `xlat_on`=1 and class 0 when `xlat_on`=0.
- R7: With class 1, `res_page` equals address bits [31:10] and `res_asid` equals `cur_asid` as sampled at the accepting edge. With any other class, both are 0.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on the outputs with `res_valid`=1 right after that edge. While `res_valid`=1 and `res_ready`=0, the outputs hold their values.
- R9: `req_ready` is 1 whenever the output register is empty or is being drained in the same cycle. With `res_ready` held at 1, one request is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| xlat_on | input | 1 | Address translation enabled |
| sq_lock | input | 1 | 1 = user mode may not use the store-queue window |
| cur_asid | input | 8 | Current address-space identifier |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_class | output | 2 | 0 pass, 1 translate, 2 store queue, 3 address error |
| res_page | output | 22 | Page number for lookup (0 unless class 1) |
| res_asid | output | 8 | Identifier for lookup (0 unless class 1) |

## Verification
The assertions check on every cycle that results under backpressure stay stable and that an accepted request produces a valid result on the next edge. They also check that non-translate results carry a zero key, and that user accesses in the upper half never come out as translate or pass. The exact class for each area, the edges of the store-queue window at 0xE3FFFFFF and 0xE4000000, the effect of `sq_lock` and `xlat_on`, and the ordering of results through stalls can only be shown by the bench's scenarios. The bench compares every delivered result with an independently computed expectation.

// File: rtl/vaddr_region_sort.sv
module vaddr_region_sort #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_priv,
  input  logic                       xlat_on,
  input  logic                       sq_lock,
  input  logic [ASID_W-1:0]          cur_asid,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [1:0]                 res_class,
  output logic [ADDR_W-PAGE_SHIFT-1:0] res_page,
  output logic [ASID_W-1:0]          res_asid
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam logic [1:0] C_PASS = 2'd0;
  localparam logic [1:0] C_XLAT = 2'd1;
  localparam logic [1:0] C_SQ   = 2'd2;
  localparam logic [1:0] C_ERR  = 2'd3;

  logic [2:0] area;
  logic       sq_win;
  logic       take;
  logic [1:0] cls;

  assign area      = req_addr[ADDR_W-1 -: 3];
  assign sq_win    = req_addr[ADDR_W-1 -: 6] == 6'b111000;
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    if (req_priv) begin
      if (area == 3'b100 || area == 3'b101 || area == 3'b111) cls = C_PASS;
      else cls = xlat_on ? C_XLAT : C_PASS;
    end else if (req_addr[ADDR_W-1]) begin
      cls = (sq_win && !sq_lock) ? C_SQ : C_ERR;
    end else begin
      cls = xlat_on ? C_XLAT : C_PASS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_class <= C_PASS;
      res_page  <= '0;
      res_asid  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_class <= cls;
      res_page  <= (cls == C_XLAT) ? req_addr[ADDR_W-1:PAGE_SHIFT] : {PAGE_W{1'b0}};
      res_asid  <= (cls == C_XLAT) ? cur_asid : {ASID_W{1'b0}};
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_class) && $stable(res_page) && $stable(res_asid));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);

  assert_key_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_class != C_XLAT |-> res_page == '0 && res_asid == '0);

  assert_user_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_priv && req_addr[ADDR_W-1] |=> res_class[1]);

  assert_p1p2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_priv && req_addr[ADDR_W-1 -: 2] == 2'b10 |=> res_class == C_PASS);

  assert_user_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_priv && !req_addr[ADDR_W-1] |=> !res_class[1]);
endmodule

// File: tb/vaddr_region_sort_test.sv
module vaddr_region_sort_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = 0;
  logic        req_priv = 0;
  logic        xlat_on = 0;
  logic        sq_lock = 0;
  logic [7:0]  cur_asid = 0;
  logic        res_valid;
  logic        res_ready = 1;
  logic [1:0]  res_class;
  logic [21:0] res_page;
  logic [7:0]  res_asid;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  bit done = 0;
  logic [31:0] expq[$];

  always #5 clk = ~clk;

  vaddr_region_sort uut (.*);

  function automatic logic [31:0] model(input logic [31:0] a, input logic p,
                                        input logic x, input logic l, input logic [7:0] id);
    logic [1:0] c;
    if (p) c = (a[31:29] == 3'b100 || a[31:29] == 3'b101 || a[31:29] == 3'b111) ? 2'd0 : (x ? 2'd1 : 2'd0);
    else if (a[31]) c = (a[31:26] == 6'b111000 && !l) ? 2'd2 : 2'd3;
    else c = x ? 2'd1 : 2'd0;
    if (c == 2'd1) return {c, a[31:10], id};
    return {c, 30'd0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic p, input logic x, input logic l, input logic [7:0] id);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_priv = p; xlat_on = x; sq_lock = l; cur_asid = id;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    expq.push_back(model(a, p, x, l, id));
    @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (ready_mode == 0) res_ready <= 1;
    else res_ready <= ($urandom_range(0, 2) != 0);
  end

  logic [31:0] held;
  bit          was_stalled = 0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (was_stalled) begin
          check(res_valid && {res_class, res_page, res_asid} == held, "R8 hold", {res_class, res_page, res_asid}, held);
        end
        was_stalled = 0;
        if (res_valid && res_ready) begin
          if (expq.size() == 0) check(0, "R8 spurious result", {res_class, res_page, res_asid}, 0);
          else begin
            logic [31:0] e;
            e = expq.pop_front();
            check({res_class, res_page, res_asid} == e, "R2-R7 class/key", {res_class, res_page, res_asid}, e);
          end
        end else if (res_valid) begin
          was_stalled = 1;
          held = {res_class, res_page, res_asid};
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && req_ready == 1, "R1 reset", {30'd0, res_valid, req_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(res_valid == 0 && req_ready == 1, "R1 after reset", {30'd0, res_valid, req_ready}, 32'h1);
    send(32'h80001234, 1, 1, 0, 8'h11);   // R2
    send(32'hA0000400, 1, 1, 0, 8'h12);   // R2
    send(32'hE0000000, 1, 1, 0, 8'h13);   // R3
    send(32'hFFFFFFFF, 1, 0, 1, 8'h14);   // R3
    send(32'h00000C00, 1, 1, 0, 8'h15);   // R4
    send(32'h7FFFFFFF, 1, 0, 0, 8'h16);   // R4
    send(32'hC0000000, 1, 1, 0, 8'h17);   // R4 area 110
    send(32'h12345678, 0, 1, 0, 8'hA5);   // R6 R7
    send(32'h12345678, 0, 0, 0, 8'hA5);   // R6
    send(32'h80000000, 0, 1, 0, 8'h01);   // R5
    send(32'hE0000000, 0, 1, 0, 8'h02);   // R5 store queue low edge
    send(32'hE3FFFFFF, 0, 1, 0, 8'h03);   // R5 store queue high edge
    send(32'hE4000000, 0, 1, 0, 8'h04);   // R5 just past window
    send(32'hE0000010, 0, 1, 1, 8'h05);   // R5 locked
    send(32'hDFFFFFFF, 0, 0, 0, 8'h06);   // R5
    // R9 throughput: back-to-back accepts with res_ready high
    begin
      int acc = 0;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        req_valid = 1; req_addr = 32'h00400000 + i * 32'h400; req_priv = 0; xlat_on = 1; cur_asid = 8'(i);
        #1;
        if (req_ready) begin acc++; expq.push_back(model(req_addr, 0, 1, 0, cur_asid)); end
        @(negedge clk);
      end
      req_valid = 0;
      check(acc == 8, "R9 throughput", acc, 8);
    end
    ready_mode = 1;
    lf = 32'h1ACE5EED;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(lf, lf[3], lf[7], lf[11], lf[19:12]);
    end
    ready_mode = 0;
    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R8 all results delivered", expq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule